// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block is the counting core of a real-time clock. A one-second strobe arrives from outside, already divided down from the crystal. Each strobe moves a calendar forward. The calendar holds seconds, minutes, hours, day of month, month and a two-digit year, each as a packed BCD byte, plus a day-of-week count. Software reaches the block through a byte-wide register port: an address, a write strobe with write data, and a read-data output that is decoded combinationally from the address.

A control register does four things:
- It starts and stops counting. While the clock is stopped, software may load any time it likes.
- It selects 12-hour or 24-hour hour coding.
- It requests one rounding of the time to the nearest minute.
- It takes a snapshot. The snapshot copies the live time into a shadow bank, and the time addresses are always read from that bank. A multi-byte read therefore sees one consistent instant, even while the counter moves on.

A status register shows whether the counter is running.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time fields read 00 (seconds), 00 (minutes), 00 (hours), 01 (day), 01 (month), 00 (year), 0 (weekday). Control and status read 0x00 and the counter is stopped.
- R2: Address map. Time fields sit at addresses 0x0 seconds, 0x1 minutes, 0x2 hours, 0x3 day, 0x4 month, 0x5 year and 0x6 weekday. Control is at 0x8 and status at 0x9. Any other address reads 0x00. Control bits: bit 0 run, bit 1 round, bit 3 twelve-hour mode, bit 6 snapshot.
- R3: A write to a time field takes effect only while the counter is stopped. While it runs, such writes are ignored.
- R4: While stopped, ticks are ignored. While running, each tick adds one second in BCD. Seconds roll 59→00 and carry into minutes; minutes roll 59→00 and carry into hours.
- R5: In 24-hour mode (control bit 3 = 0) hours count 00..23. The step from 23 to 00 advances the day.
- R6: In 12-hour mode (control bit 3 = 1) hour bits 6:0 hold BCD 01..12 and bit 7 is the PM flag. The step 11→12 toggles PM and 12→01 keeps it. The step from 11 PM to 12 AM advances the day.
- R7: The day rolls to 01 after day 28, 29, 30 or 31, according to the month. February has 29 days when the binary year is divisible by 4.
- R8: When the day rolls over, month 12 goes to 01 and advances the year, and year 99 goes to 00.
- R9: The weekday counts 0..6 and steps once on every day rollover, wrapping 6→0.
- R10: Writing control with bit 6 = 1 copies the live time into the shadow bank that the time addresses read from. If a tick lands in the same cycle, the copy holds the value before that tick. Bit 6 reads back 0.
- R11: Writing control with bit 1 = 1 marks a round as pending, and bit 1 then reads 1. The next running tick sets seconds to 00 instead of counting. If seconds were 30 or more, it also advances the minute with full carry. It then clears the pending mark.
- R12: Status bit 1 equals the run bit. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from addr |

## Verification
Two events can arrive in the same clock edge: a snapshot request and a running tick. The bench drives both together. It then reads the shadow bank, which must show the pre-tick seconds. A second snapshot must show the advanced value. Round requests are also placed on ticks, including a case whose carry ripples through minutes, hours, day, month and weekday at once. Beyond these collisions, the bench sweeps more than an hour of seconds, every hour boundary in both hour modes, and the last day of every month across all hundred years, all against arithmetic expectations.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_FIELDS = 7;

    // seconds occupy the low byte, weekday the high byte
    typedef struct packed {
        logic [7:0] wk;
        logic [7:0] yr;
        logic [7:0] mo;
        logic [7:0] dy;
        logic [7:0] hr;
        logic [7:0] mi;
        logic [7:0] se;
    } rtc_time_t;

    typedef struct packed {
        rtc_time_t live;
        rtc_time_t shadow;
        logic      run;
        logic      rnd;
        logic      h12;
    } core_state_t;

    localparam logic [7:0] SEC_MAX  = 8'h59;
    localparam logic [7:0] HR24_MAX = 8'h23;
    localparam logic [7:0] MON_MAX  = 8'h12;
    localparam logic [7:0] YR_MAX   = 8'h99;
    localparam logic [7:0] WK_MAX   = 8'h06;

    localparam rtc_time_t RST_TIME = '{wk: 8'h00, yr: 8'h00, mo: 8'h01,
                                       dy: 8'h01, hr: 8'h00, mi: 8'h00,
                                       se: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
(
    input  logic [7:0] month_i,
    input  logic [7:0] year_i,
    output logic [7:0] last_day_o
);
    logic leap;

    // binary year divisible by 4: even tens with ones 0/4/8, odd tens with 2/6
    always_comb begin
        if (!year_i[4])
            leap = (year_i[3:0] == 4'd0) || (year_i[3:0] == 4'd4) || (year_i[3:0] == 4'd8);
        else
            leap = (year_i[3:0] == 4'd2) || (year_i[3:0] == 4'd6);
    end

    always_comb begin
        case (month_i)
            8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
            default:                    last_day_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_time_advance.sv
module rtc_time_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur_i,
    input  logic      h12_i,
    input  logic      round_i,
    output rtc_time_t nxt_o
);
    typedef struct packed {
        rtc_time_t t;
        logic      c_min;
        logic      c_hr;
        logic      c_day;
        logic      c_mon;
    } adv_t;

    adv_t       a_d;
    logic [7:0] last_day;
    logic [7:0] hr12_inc;

    rtc_month_len u_len (
        .month_i    (cur_i.mo),
        .year_i     (cur_i.yr),
        .last_day_o (last_day)
    );

    assign hr12_inc = bcd_inc({1'b0, cur_i.hr[6:0]});

    always_comb begin
        a_d   = '0;
        a_d.t = cur_i;

        if (round_i) begin
            a_d.t.se  = 8'h00;
            a_d.c_min = (cur_i.se >= 8'h30);
        end else if (cur_i.se == SEC_MAX) begin
            a_d.t.se  = 8'h00;
            a_d.c_min = 1'b1;
        end else begin
            a_d.t.se  = bcd_inc(cur_i.se);
        end

        if (a_d.c_min) begin
            if (cur_i.mi == SEC_MAX) begin
                a_d.t.mi = 8'h00;
                a_d.c_hr = 1'b1;
            end else begin
                a_d.t.mi = bcd_inc(cur_i.mi);
            end
        end

        if (a_d.c_hr) begin
            if (h12_i) begin
                if (cur_i.hr[6:0] == 7'h12) begin
                    a_d.t.hr = {cur_i.hr[7], 7'h01};
                end else if (cur_i.hr[6:0] == 7'h11) begin
                    a_d.t.hr  = {~cur_i.hr[7], 7'h12};
                    a_d.c_day = cur_i.hr[7];
                end else begin
                    a_d.t.hr = {cur_i.hr[7], hr12_inc[6:0]};
                end
            end else if (cur_i.hr == HR24_MAX) begin
                a_d.t.hr  = 8'h00;
                a_d.c_day = 1'b1;
            end else begin
                a_d.t.hr = bcd_inc(cur_i.hr);
            end
        end

        if (a_d.c_day) begin
            a_d.t.wk = (cur_i.wk >= WK_MAX) ? 8'h00 : cur_i.wk + 8'h01;
            if (cur_i.dy >= last_day) begin
                a_d.t.dy  = 8'h01;
                a_d.c_mon = 1'b1;
            end else begin
                a_d.t.dy = bcd_inc(cur_i.dy);
            end
        end

        if (a_d.c_mon) begin
            if (cur_i.mo >= MON_MAX) begin
                a_d.t.mo = 8'h01;
                a_d.t.yr = (cur_i.yr == YR_MAX) ? 8'h00 : bcd_inc(cur_i.yr);
            end else begin
                a_d.t.mo = bcd_inc(cur_i.mo);
            end
        end
    end

    assign nxt_o = a_d.t;
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 8,
    parameter int STAT_ADDR = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NUM_FIELDS - 1);

    core_state_t s_d, s_q;
    rtc_time_t   nxt_time;
    logic        wr_ctl, wr_time, adv;

    rtc_time_advance u_adv (
        .cur_i   (s_q.live),
        .h12_i   (s_q.h12),
        .round_i (s_q.rnd),
        .nxt_o   (nxt_time)
    );

    assign wr_ctl  = wr_en && (addr == A_CTRL);
    assign wr_time = wr_en && (addr <= A_LAST);
    assign adv     = tick_1s && s_q.run;

    always_comb begin
        s_d = s_q;
        if (adv) begin
            s_d.live = nxt_time;
            s_d.rnd  = 1'b0;
        end
        if (wr_ctl) begin
            s_d.run = wdata[0];
            s_d.h12 = wdata[3];
            if (wdata[1]) s_d.rnd = 1'b1;
            if (wdata[6]) s_d.shadow = s_q.live;
        end
        if (wr_time && !s_q.run) begin
            case (addr)
                ADDR_W'(0): s_d.live.se = wdata;
                ADDR_W'(1): s_d.live.mi = wdata;
                ADDR_W'(2): s_d.live.hr = wdata;
                ADDR_W'(3): s_d.live.dy = wdata;
                ADDR_W'(4): s_d.live.mo = wdata;
                ADDR_W'(5): s_d.live.yr = wdata;
                default:    s_d.live.wk = wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.live   <= RST_TIME;
            s_q.shadow <= RST_TIME;
            s_q.run    <= 1'b0;
            s_q.rnd    <= 1'b0;
            s_q.h12    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(0): rdata = s_q.shadow.se;
            ADDR_W'(1): rdata = s_q.shadow.mi;
            ADDR_W'(2): rdata = s_q.shadow.hr;
            ADDR_W'(3): rdata = s_q.shadow.dy;
            ADDR_W'(4): rdata = s_q.shadow.mo;
            ADDR_W'(5): rdata = s_q.shadow.yr;
            ADDR_W'(6): rdata = s_q.shadow.wk;
            A_CTRL:     rdata = {4'b0000, s_q.h12, 1'b0, s_q.rnd, s_q.run};
            A_STAT:     rdata = {6'b000000, s_q.run, 1'b0};
            default:    rdata = 8'h00;
        endcase
    end

    // stopped and no field write: the live time must not move
    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !wr_time) |=> $stable(s_q.live));

    // running without a tick: field writes leave the live time alone
    assert_ignore_running_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !tick_1s) |=> $stable(s_q.live));

    // snapshot copies the pre-edge live time even when a tick coincides
    assert_snapshot_coherent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[6]) |=> (s_q.shadow == $past(s_q.live)));

    // a round applied by a tick clears itself unless re-requested
    assert_round_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s_q.rnd && !(wr_ctl && wdata[1])) |=> !s_q.rnd);

    // a round leaves seconds at zero
    assert_round_zero_sec_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s_q.rnd) |=> (s_q.live.se == 8'h00));

    // status running flag follows the run bit
    assert_status_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_STAT) |-> (rdata[1] == s_q.run));
endmodule

// File: tb/tb_rtc_bcd_core.sv
module tb_rtc_bcd_core;
    localparam int ADDR_W = 4;
    localparam logic [3:0] A_CTRL = 4'h8;
    localparam logic [3:0] A_STAT = 4'h9;

    logic       clk = 1'b0;
    logic       rst_n, tick_1s, wr_en;
    logic [3:0] addr;
    logic [7:0] wdata, rdata;
    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    rtc_bcd_core #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] enc12(input int h);
        int hh;
        hh = (h % 12 == 0) ? 12 : h % 12;
        return {(h >= 12) ? 1'b1 : 1'b0, 7'(bcd(hh))};
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] mode, input logic [7:0] se, mi, hr,
                            dy, mo, yr, wk);
        wr(A_CTRL, mode);
        wr(4'h0, se); wr(4'h1, mi); wr(4'h2, hr); wr(4'h3, dy);
        wr(4'h4, mo); wr(4'h5, yr); wr(4'h6, wk);
        wr(A_CTRL, mode | 8'h01);
    endtask

    task automatic expect_field(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; tick_1s = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values, R2 map
        expect_field("R1 sec", 4'h0, 8'h00);
        expect_field("R1 min", 4'h1, 8'h00);
        expect_field("R1 hour", 4'h2, 8'h00);
        expect_field("R1 day", 4'h3, 8'h01);
        expect_field("R1 month", 4'h4, 8'h01);
        expect_field("R1 year", 4'h5, 8'h00);
        expect_field("R1 week", 4'h6, 8'h00);
        expect_field("R1 ctrl", A_CTRL, 8'h00);
        expect_field("R1 status", A_STAT, 8'h00);
        expect_field("R2 unmapped", 4'h7, 8'h00);

        // R12 status follows run, R2 control readback
        wr(A_CTRL, 8'h01);
        expect_field("R12 status running", A_STAT, 8'h02);
        expect_field("R2 ctrl run", A_CTRL, 8'h01);

        // R3 write ignored while running
        wr(4'h0, 8'h45);
        wr(4'h1, 8'h33);
        wr(A_CTRL, 8'h41);
        expect_field("R3 sec kept", 4'h0, 8'h00);
        expect_field("R3 min kept", 4'h1, 8'h00);

        // R4 seconds/minutes/hours sweep from zero
        for (int n = 1; n <= 3700; n++) begin
            tick();
            wr(A_CTRL, 8'h41);
            expect_field("R4 sec", 4'h0, bcd(n % 60));
            expect_field("R4 min", 4'h1, bcd((n / 60) % 60));
            expect_field("R4 hour", 4'h2, bcd(n / 3600));
        end

        // R4 stopped ticks ignored
        wr(A_CTRL, 8'h00);
        expect_field("R12 status stopped", A_STAT, 8'h00);
        repeat (5) tick();
        wr(A_CTRL, 8'h40);
        expect_field("R4 stopped sec", 4'h0, 8'h40);
        expect_field("R4 stopped min", 4'h1, 8'h01);
        expect_field("R4 stopped hour", 4'h2, 8'h01);

        // R10 snapshot coinciding with a tick
        set_time(8'h00, 8'h30, 8'h20, 8'h10, 8'h15, 8'h06, 8'h40, 8'h03);
        @(negedge clk);
        tick_1s = 1'b1; wr_en = 1'b1; addr = A_CTRL; wdata = 8'h41;
        @(negedge clk);
        tick_1s = 1'b0; wr_en = 1'b0;
        expect_field("R10 pre-tick sec", 4'h0, 8'h30);
        expect_field("R10 pre-tick min", 4'h1, 8'h20);
        expect_field("R10 snapshot bit reads 0", A_CTRL, 8'h01);
        wr(A_CTRL, 8'h41);
        expect_field("R10 post-tick sec", 4'h0, 8'h31);

        // R11 round up
        set_time(8'h00, 8'h45, 8'h20, 8'h10, 8'h15, 8'h06, 8'h40, 8'h03);
        wr(A_CTRL, 8'h03);
        expect_field("R11 pending", A_CTRL, 8'h03);
        tick();
        wr(A_CTRL, 8'h41);
        expect_field("R11 up sec", 4'h0, 8'h00);
        expect_field("R11 up min", 4'h1, 8'h21);
        expect_field("R11 cleared", A_CTRL, 8'h01);
        // R11 round down
        set_time(8'h00, 8'h29, 8'h20, 8'h10, 8'h15, 8'h06, 8'h40, 8'h03);
        wr(A_CTRL, 8'h03);
        tick();
        wr(A_CTRL, 8'h41);
        expect_field("R11 down sec", 4'h0, 8'h00);
        expect_field("R11 down min", 4'h1, 8'h20);
        // R11 round with full carry, stopped pending survives ticks
        set_time(8'h00, 8'h30, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h06);
        wr(A_CTRL, 8'h02);
        tick();
        expect_field("R11 pending while stopped", A_CTRL, 8'h02);
        wr(A_CTRL, 8'h01);
        tick();
        wr(A_CTRL, 8'h41);
        expect_field("R11 carry sec", 4'h0, 8'h00);
        expect_field("R11 carry min", 4'h1, 8'h00);
        expect_field("R11 carry hour", 4'h2, 8'h00);
        expect_field("R11 carry day", 4'h3, 8'h01);
        expect_field("R11 carry month", 4'h4, 8'h03);
        expect_field("R11 carry week", 4'h6, 8'h00);

        // R5 24-hour and R6 12-hour sweeps of every hour boundary
        for (int h = 0; h < 24; h++) begin
            set_time(8'h00, 8'h59, 8'h59, bcd(h), 8'h10, 8'h05, 8'h30, 8'h02);
            tick();
            wr(A_CTRL, 8'h41);
            expect_field("R5 hour", 4'h2, bcd((h + 1) % 24));
            expect_field("R5 day", 4'h3, (h == 23) ? 8'h11 : 8'h10);
            expect_field("R9 week 24h", 4'h6, (h == 23) ? 8'h03 : 8'h02);
        end
        for (int h = 0; h < 24; h++) begin
            set_time(8'h08, 8'h59, 8'h59, enc12(h), 8'h10, 8'h05, 8'h30, 8'h02);
            tick();
            wr(A_CTRL, 8'h49);
            expect_field("R6 hour", 4'h2, enc12((h + 1) % 24));
            expect_field("R6 day", 4'h3, (h == 23) ? 8'h11 : 8'h10);
            expect_field("R6 ctrl mode", A_CTRL, 8'h09);
        end

        // R7 R8 R9 month ends over all years
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int d;
                int w;
                d = dim(m, y);
                w = (y + m) % 7;
                set_time(8'h00, 8'h59, 8'h59, 8'h23, bcd(d - 1), bcd(m), bcd(y), 8'(w));
                tick();
                wr(A_CTRL, 8'h41);
                expect_field("R7 no early roll", 4'h3, bcd(d));
                set_time(8'h00, 8'h59, 8'h59, 8'h23, bcd(d), bcd(m), bcd(y), 8'(w));
                tick();
                wr(A_CTRL, 8'h41);
                expect_field("R7 day roll", 4'h3, 8'h01);
                expect_field("R8 month", 4'h4, bcd((m == 12) ? 1 : m + 1));
                expect_field("R8 year", 4'h5, bcd((m == 12) ? (y + 1) % 100 : y));
                expect_field("R9 week", 4'h6, 8'((w + 1) % 7));
                expect_field("R5 hour wrap", 4'h2, 8'h00);
            end
        end

        finish_run();
    end
endmodule